// File: doc/BRIEF.md
# Change-of-State Interrupt Input Port

This block is a read-only port for 48 digital inputs, reached over a byte-wide host bus through an eight-byte address window. The inputs are split into six groups of eight. The host reads each group as one byte. A single control/status location sits at the top of the window. When the host writes that location, the value sets which groups may report changes. When the host reads it, the value shows which groups changed and whether an interrupt is pending.

Each input passes through a two-flop synchroniser. A change is any difference between two consecutive synchronised samples, so both rising and falling edges count. In an enabled group, a change sets that group's flag. The interrupt output stays high as long as any flag is set. Reading the status location returns the flags and then clears them. A change that lands in the same cycle as that read is kept for the next interrupt.

Top module: `cos_input_port`

## Requirements
- R1: A read at offset 0, 1, 2, 4, 5 or 6 returns, combinationally, the synchronised byte of input group 0, 1, 2, 3, 4 or 5. Bit n of that byte is input 8*group+n.
- R2: A read at offset 3 returns 0x00.
- R3: A write at offset 7 stores bits 0 to 5 of the write data as the group enable mask, where bit g enables group g. After reset the mask is zero, and with a zero mask no change is latched.
- R4: In an enabled group, any rising or falling input edge sets that group's flag. Bit g of the offset-7 read value shows the flag of group g. The flag is set at the third rising clock edge after the pin changes.
- R5: A change on an input of a disabled group sets no flag and does not raise the interrupt.
- R6: In the offset-7 read value, bit 6 reads 0 while the interrupt is pending and 1 otherwise, and bit 7 always reads 0.
- R7: `irq_o` is an active-high level that is high exactly while at least one group flag is set.
- R8: A read at offset 7 clears all flags at the clock edge that ends the read. A change that is latched at that same edge is kept, and the interrupt stays high.
- R9: Writing a mask that clears a group's enable bit also clears that group's pending flag.
- R10: Writes at offsets 0 to 6 change neither the enable mask nor the flags.
- R11: After reset, `irq_o` is 0 and the offset-7 read value is 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 48 | Asynchronous digital inputs |
| bus_addr | input | 3 | Byte offset inside the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while bus_rd is high |
| irq_o | output | 1 | Active-high interrupt level |

## Verification
Two actions can land on the same clock edge: the read that clears the status, and the latching of a new group change. The bench forces this collision. It first leaves a flag pending in one group. It then toggles an input in a second group two edges before it issues the status read. This makes the synchronised edge reach the flag register on the very edge that ends the read. The check passes when the read returns only the older group, and a following read returns only the newer group with the interrupt still high.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned STATUS_OFS = 7;
  localparam int unsigned HOLE_OFS   = 3;

  // Map a bus offset to a data group index; returns 4'hF when the offset
  // carries no input byte.
  function automatic logic [3:0] slot_of(input logic [2:0] ofs);
    if (ofs == 3'(HOLE_OFS) || ofs == 3'(STATUS_OFS)) return 4'hF;
    if (ofs < 3'(HOLE_OFS)) return {1'b0, ofs};
    return {1'b0, ofs - 3'd1};
  endfunction

  // Compose the status byte: bit 7 zero, bit 6 active-low pending, flags low.
  function automatic logic [7:0] status_of(input logic [5:0] flags, input logic pend);
    return {1'b0, ~pend, flags};
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned W      = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev_q <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev_q <= pipe[STAGES-1];
    end
  end

  assign q_o   = pipe[STAGES-1];
  assign chg_o = pipe[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cos_flags.sv
module cos_flags #(
  parameter int unsigned GROUPS = 6,
  parameter int unsigned GW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS*GW-1:0] chg_i,
  input  logic [GROUPS-1:0]    en_i,
  input  logic                 en_wr_i,
  input  logic [GROUPS-1:0]    en_new_i,
  input  logic                 clr_i,
  output logic [GROUPS-1:0]    grp_chg_o,
  output logic [GROUPS-1:0]    flags_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_chg_o[g] = |chg_i[g*GW +: GW];
  end

  logic [GROUPS-1:0] keep_mask;
  logic [GROUPS-1:0] flags_d;

  always_comb begin
    keep_mask = en_wr_i ? en_new_i : en_i;
    flags_d   = ((clr_i ? '0 : flags_o) | (grp_chg_o & en_i)) & keep_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= flags_d;
  end
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int unsigned GROUPS = 6,
  parameter int unsigned GW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [GW-1:0]        wdata_i,
  input  logic [GROUPS*GW-1:0] sync_i,
  input  logic [GROUPS-1:0]    flags_i,
  input  logic                 pend_i,
  output logic [GROUPS-1:0]    en_o,
  output logic                 en_wr_o,
  output logic                 stat_rd_o,
  output logic [GW-1:0]        rdata_o
);
  logic [3:0] slot;
  logic       at_status;
  logic       unused_wbits;

  assign slot         = slot_of(addr_i);
  assign at_status    = (addr_i == 3'(STATUS_OFS));
  assign en_wr_o      = wr_i && at_status;
  assign stat_rd_o    = rd_i && at_status;
  assign unused_wbits = ^wdata_i[GW-1:GROUPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_o <= '0;
    else if (en_wr_o) en_o <= wdata_i[GROUPS-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (at_status)                     rdata_o = status_of(flags_i, pend_i);
    else if (slot < 4'(GROUPS))        rdata_o = sync_i[slot*GW +: GW];
  end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port #(
  parameter int unsigned GROUPS = 6,
  parameter int unsigned GW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS*GW-1:0] pins_i,
  input  logic [2:0]           bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [GW-1:0]        bus_wdata,
  output logic [GW-1:0]        bus_rdata,
  output logic                 irq_o
);
  localparam int unsigned NPINS = GROUPS * GW;

  logic [NPINS-1:0]  sync_q;
  logic [NPINS-1:0]  pin_chg;
  logic [GROUPS-1:0] grp_chg;
  logic [GROUPS-1:0] grp_flag;
  logic [GROUPS-1:0] grp_en;
  logic              en_wr;
  logic              stat_rd;

  cos_sync #(.W(NPINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(sync_q), .chg_o(pin_chg)
  );

  cos_flags #(.GROUPS(GROUPS), .GW(GW)) u_flags (
    .clk(clk), .rst_n(rst_n), .chg_i(pin_chg), .en_i(grp_en),
    .en_wr_i(en_wr), .en_new_i(bus_wdata[GROUPS-1:0]), .clr_i(stat_rd),
    .grp_chg_o(grp_chg), .flags_o(grp_flag)
  );

  cos_regs #(.GROUPS(GROUPS), .GW(GW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .rd_i(bus_rd), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .sync_i(sync_q), .flags_i(grp_flag), .pend_i(irq_o),
    .en_o(grp_en), .en_wr_o(en_wr), .stat_rd_o(stat_rd), .rdata_o(bus_rdata)
  );

  assign irq_o = |grp_flag;
endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk #(
  parameter int unsigned GROUPS = 6,
  parameter int unsigned GW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [GW-1:0]     bus_rdata,
  input logic              irq_o,
  input logic [GROUPS-1:0] grp_chg,
  input logic [GROUPS-1:0] grp_flag,
  input logic [GROUPS-1:0] grp_en,
  input logic              stat_rd,
  input logic              en_wr
);
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3) |-> (bus_rdata == '0)); // R2
  AST_NO_DISABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_flag & ~grp_en) == '0)); // R5
  AST_EDGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grp_chg & grp_en) && !en_wr) |=> irq_o); // R4
  AST_PEND_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd7) |-> (bus_rdata[6] == !irq_o && !bus_rdata[7])); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(|(grp_chg & grp_en))) |=> !irq_o); // R8
  AST_OTHER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 3'd7) |=> $stable(grp_en)); // R10
endmodule

bind cos_input_port cos_input_port_chk #(.GROUPS(GROUPS), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq_o(irq_o), .grp_chg(grp_chg),
  .grp_flag(grp_flag), .grp_en(grp_en), .stat_rd(stat_rd), .en_wr(en_wr)
);

// File: tb/cos_input_port_tb.sv
module cos_input_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] pins = '0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cos_input_port u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_addr(addr), .bus_rd(rd),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Read one offset; data captured before the edge that ends the access.
  task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R11 irq after reset", {7'd0, irq}, 8'h00);
    bus_read(3'd7, v);
    check("R11 status after reset", v, 8'h40);
  endtask

  task automatic t_group_reads();
    logic [7:0] v;
    logic [7:0] pat [6] = '{8'hA5, 8'h3C, 8'h81, 8'h7E, 8'h12, 8'hF0};
    for (int g = 0; g < 6; g++) pins[g*8 +: 8] = pat[g];
    settle();
    for (int g = 0; g < 6; g++) begin
      bus_read(g < 3 ? 3'(g) : 3'(g + 1), v);
      check($sformatf("R1 group %0d byte", g), v, pat[g]);
    end
    bus_read(3'd3, v);
    check("R2 offset 3 reads zero", v, 8'h00);
    bus_read(3'd7, v);
    check("R3 zero mask latches nothing", v, 8'h40);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    bus_write(3'd7, 8'h3F);
    @(negedge clk);
    pins[17] = ~pins[17];
    @(negedge clk); @(negedge clk);
    check("R4 no flag before third edge", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R7 irq after third edge", {7'd0, irq}, 8'h01);
    bus_read(3'd7, v);
    check("R4 R6 status after edge", v, 8'h04);
    check("R8 irq cleared by read", {7'd0, irq}, 8'h00);
    bus_read(3'd7, v);
    check("R8 status cleared", v, 8'h40);
    pins[17] = ~pins[17];
    settle();
    bus_read(3'd7, v);
    check("R4 opposite edge also flags", v, 8'h04);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    bus_write(3'd7, 8'h01);
    pins[24] = ~pins[24];
    settle();
    check("R5 irq stays low", {7'd0, irq}, 8'h00);
    bus_read(3'd7, v);
    check("R5 disabled group not latched", v, 8'h40);
  endtask

  task automatic t_disable_clears();
    logic [7:0] v;
    bus_write(3'd7, 8'h3F);
    pins[33] = ~pins[33];
    settle();
    check("R9 irq before disable", {7'd0, irq}, 8'h01);
    bus_write(3'd7, 8'h2F);
    check("R9 irq after disable", {7'd0, irq}, 8'h00);
    bus_read(3'd7, v);
    check("R9 flag gone", v, 8'h40);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] v;
    bus_write(3'd7, 8'h01);
    for (int a = 0; a < 7; a++) bus_write(3'(a), 8'h00);
    pins[3] = ~pins[3];
    settle();
    for (int a = 0; a < 7; a++) bus_write(3'(a), 8'hFF);
    check("R10 irq kept", {7'd0, irq}, 8'h01);
    bus_read(3'd7, v);
    check("R10 mask and flag kept", v, 8'h01);
    pins[8] = ~pins[8];
    settle();
    bus_read(3'd7, v);
    check("R10 group 1 still disabled", v, 8'h40);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    bus_write(3'd7, 8'h03);
    pins[9] = ~pins[9];
    settle();
    pins[0] = ~pins[0];
    @(negedge clk); @(negedge clk);
    addr = 3'd7; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
    check("R8 read sees older group", v, 8'h02);
    check("R8 irq held by new change", {7'd0, irq}, 8'h01);
    bus_read(3'd7, v);
    check("R8 newer change kept", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_group_reads();
    t_edges();
    t_disabled();
    t_disable_clears();
    t_ignored_writes();
    t_same_cycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule